// File: doc/BRIEF.md
# Storage-Card Task-File Register Interface with Byte Lanes

This block is the slave side of a task-file register set for a removable storage card on a 16-bit host bus. Each host access carries two active-low card enables (`ce_hi_n` for the upper byte lane, `ce_lo_n` for the lower one), an address bit `a0` and a register offset. From these the block works out the access width and the byte lane used. It then steers the data word, the error/feature byte or the sector-count byte onto bits 15:0, bits 7:0 or bits 15:8 of the bus.

One offset does two jobs. A host read there returns the error byte. A host write there stores a feature byte for the media side.

The sector-count register holds the number of sectors still to be moved. The host loads it, and the media side steps it down with a one-cycle strobe after each finished sector. A loaded value of zero means 256 sectors, so the count is kept in 9 bits. If the command fails, the remainder stays in place for the host to read. The error byte is filled from a media-side fault strobe and is cleared when a new command is started.

Top module: `ata_tf_regfile`

## Requirements
- R1: With both enables low, a read at offset 0, 8 or 9 returns the whole 16-bit data word on bits 15:0. A write at those offsets stores all 16 bits.
- R2: With only `ce_lo_n` low, an access at offset 0, 8 or 9 moves one data byte on bits 7:0. `a0`=0 selects the even byte (data word bits 7:0) and `a0`=1 selects the odd byte (data word bits 15:8). Bits 15:8 of the read bus are 0.
- R3: With only `ce_hi_n` low, an access at offset 8 or 9 moves the odd data byte on bits 15:8. Bits 7:0 of the read bus are 0.
- R4: Offsets 1 and 13 read the error byte and write the feature byte. This uses bits 7:0 when `ce_lo_n` is low, and bits 15:8 when only `ce_hi_n` is low. With only `ce_hi_n` low, offset 0 also reaches the error/feature byte on bits 15:8.
- R5: On a fault strobe, the 5-bit cause vector bits 4,3,2,1,0 load error bits 7 (bad block), 6 (uncorrectable), 4 (sector ID not found), 2 (aborted) and 0 (general error). Error bits 5, 3 and 1 always read 0.
- R6: A command-start strobe clears the error byte. If a fault strobe comes in the same cycle, the fault strobe wins.
- R7: A host write of a byte to offset 2 (with `ce_lo_n` low, on bits 7:0) loads the count. The value 0 loads 256. Offset 2 reads back the low 8 bits of the count, so 256 reads as 0.
- R8: Each sector-done strobe lowers a nonzero count by one. The count stays at 0 once it reaches 0. A host load in the same cycle wins. After a failed transfer the remainder stays readable.
- R9: With both enables high, the read bus is 0 and writes change nothing.
- R10: An offset that the current enable mode does not decode reads 0 and ignores writes. The read bus is also 0 whenever `host_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_hi_n | input | 1 | Upper byte lane enable, active low |
| ce_lo_n | input | 1 | Lower byte lane enable, active low |
| a0 | input | 1 | Byte select for byte-wide data accesses |
| reg_ofs | input | 4 | Register offset |
| host_rd | input | 1 | Host read cycle |
| host_wr | input | 1 | Host write cycle, takes effect at the clock edge |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational from the inputs and the stored registers |
| cmd_start | input | 1 | New command strobe, clears the error byte |
| sector_done | input | 1 | Media-side sector-finished strobe |
| fault_strobe | input | 1 | Media-side fault strobe |
| fault_cause | input | 5 | Fault cause vector loaded into the error byte |
| data_word | output | 16 | Stored data word |
| feature | output | 8 | Stored feature byte |
| sectors_left | output | 9 | Remaining sector count, 1 to 256 or 0 |

## Verification
Read data is combinational. The bench compares `host_rdata` within the same cycle, one time unit after the inputs are driven at the falling edge, before any register changes. A write, a count load, a sector step, a fault or a clear shows up on `data_word`, `feature`, `sectors_left` and later reads after exactly one rising edge. The bench updates its model just after that edge and compares the stored outputs at the next falling edge. It does this before driving the next access, so every check sees exactly one cycle of register update.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam int BUS_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int LANES   = BUS_W / BYTE_W;
  localparam int CAUSE_W = 5;
  localparam int CNT_W   = BYTE_W + 1;
  localparam int CNT_MAX = 1 << BYTE_W;

  localparam int OFS_DATA     = 0;
  localparam int OFS_ERRFEAT  = 1;
  localparam int OFS_COUNT    = 2;
  localparam int OFS_DATA_A   = 8;
  localparam int OFS_DATA_B   = 9;
  localparam int OFS_ERRFEAT2 = 13;

  typedef enum logic [1:0] {
    LANE_NONE,
    LANE_WORD,
    LANE_LOW,
    LANE_HIGH
  } lane_mode_e;

  typedef struct packed {
    lane_mode_e lane;
    logic       hit_data;
    logic       hit_ef;
    logic       hit_cnt;
    logic       odd_byte;
  } tf_sel_t;

  // Spread the cause vector onto the fixed error bit positions.
  function automatic logic [BYTE_W-1:0] pack_fault(input logic [CAUSE_W-1:0] c);
    pack_fault = {c[4], c[3], 1'b0, c[2], 1'b0, c[1], 1'b0, c[0]};
  endfunction

  // A zero byte stands for the full 256-sector request.
  function automatic logic [CNT_W-1:0] count_load(input logic [BYTE_W-1:0] b);
    count_load = (b == '0) ? CNT_W'(CNT_MAX) : {1'b0, b};
  endfunction

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] n);
    count_step = (n == '0) ? '0 : n - CNT_W'(1);
  endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic             ce_hi_n,
  input  logic             ce_lo_n,
  input  logic             a0,
  input  logic [OFS_W-1:0] reg_ofs,
  output tf_sel_t          sel
);

  logic is_data, is_odd_data, is_ef, is_cnt, is_zero;

  always_comb begin
    is_zero     = (reg_ofs == OFS_W'(OFS_DATA));
    is_odd_data = (reg_ofs == OFS_W'(OFS_DATA_A)) || (reg_ofs == OFS_W'(OFS_DATA_B));
    is_data     = is_zero || is_odd_data;
    is_ef       = (reg_ofs == OFS_W'(OFS_ERRFEAT)) || (reg_ofs == OFS_W'(OFS_ERRFEAT2));
    is_cnt      = (reg_ofs == OFS_W'(OFS_COUNT));
  end

  always_comb begin
    sel = '{lane: LANE_NONE, hit_data: 1'b0, hit_ef: 1'b0, hit_cnt: 1'b0, odd_byte: 1'b0};
    unique case ({ce_hi_n, ce_lo_n})
      2'b00: begin
        if (is_data) begin
          sel.lane     = LANE_WORD;
          sel.hit_data = 1'b1;
        end else if (is_ef || is_cnt) begin
          sel.lane    = LANE_LOW;
          sel.hit_ef  = is_ef;
          sel.hit_cnt = is_cnt;
        end
      end
      2'b10: begin
        if (is_data || is_ef || is_cnt) begin
          sel.lane     = LANE_LOW;
          sel.hit_data = is_data;
          sel.hit_ef   = is_ef;
          sel.hit_cnt  = is_cnt;
          sel.odd_byte = is_data && a0;
        end
      end
      2'b01: begin
        if (is_odd_data) begin
          sel.lane     = LANE_HIGH;
          sel.hit_data = 1'b1;
          sel.odd_byte = 1'b1;
        end else if (is_ef || is_zero) begin
          sel.lane   = LANE_HIGH;
          sel.hit_ef = 1'b1;
        end
      end
      default: sel.lane = LANE_NONE;
    endcase
  end

endmodule

// File: rtl/ata_tf_seccount.sv
module ata_tf_seccount
  import ata_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              step,
  output logic [CNT_W-1:0]  count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= count_load(load_byte);
    else if (step) count <= count_step(count);
  end

endmodule

// File: rtl/ata_tf_errfeat.sv
module ata_tf_errfeat
  import ata_tf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_strobe,
  input  logic [CAUSE_W-1:0] fault_cause,
  input  logic               clear,
  input  logic               feat_we,
  input  logic [BYTE_W-1:0]  feat_byte,
  output logic [BYTE_W-1:0]  err_q,
  output logic [BYTE_W-1:0]  feat_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            err_q <= '0;
    else if (fault_strobe) err_q <= pack_fault(fault_cause);
    else if (clear)        err_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       feat_q <= '0;
    else if (feat_we) feat_q <= feat_byte;
  end

endmodule

// File: rtl/ata_tf_regfile.sv
module ata_tf_regfile
  import ata_tf_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_hi_n,
  input  logic               ce_lo_n,
  input  logic               a0,
  input  logic [OFS_W-1:0]   reg_ofs,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [BUS_W-1:0]   host_wdata,
  output logic [BUS_W-1:0]   host_rdata,
  input  logic               cmd_start,
  input  logic               sector_done,
  input  logic               fault_strobe,
  input  logic [CAUSE_W-1:0] fault_cause,
  output logic [BUS_W-1:0]   data_word,
  output logic [BYTE_W-1:0]  feature,
  output logic [CNT_W-1:0]   sectors_left
);

  tf_sel_t            sel;
  logic               wr_ok;
  logic [BYTE_W-1:0]  wr_byte;
  logic [BYTE_W-1:0]  rd_byte;
  logic [BYTE_W-1:0]  err_bits;
  logic               data_wr_ev;
  logic               feat_wr_ev;
  logic               cnt_load_ev;
  logic [LANES-1:0]   lane_we;
  logic [BYTE_W-1:0]  data_b [LANES];

  ata_tf_decode #(.OFS_W(OFS_W)) u_decode (
    .ce_hi_n (ce_hi_n),
    .ce_lo_n (ce_lo_n),
    .a0      (a0),
    .reg_ofs (reg_ofs),
    .sel     (sel)
  );

  always_comb begin
    wr_ok       = host_wr && (sel.lane != LANE_NONE);
    wr_byte     = (sel.lane == LANE_HIGH) ? host_wdata[BUS_W-1 -: BYTE_W] : host_wdata[BYTE_W-1:0];
    data_wr_ev  = wr_ok && sel.hit_data;
    feat_wr_ev  = wr_ok && sel.hit_ef;
    cnt_load_ev = wr_ok && sel.hit_cnt;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_wd;
    always_comb begin
      lane_we[g] = data_wr_ev && ((sel.lane == LANE_WORD) || (sel.odd_byte == (g != 0)));
      lane_wd    = (sel.lane == LANE_WORD) ? host_wdata[g*BYTE_W +: BYTE_W] : wr_byte;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          data_b[g] <= '0;
      else if (lane_we[g]) data_b[g] <= lane_wd;
    end
    assign data_word[g*BYTE_W +: BYTE_W] = data_b[g];
  end

  ata_tf_errfeat u_errfeat (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_strobe (fault_strobe),
    .fault_cause  (fault_cause),
    .clear        (cmd_start),
    .feat_we      (feat_wr_ev),
    .feat_byte    (wr_byte),
    .err_q        (err_bits),
    .feat_q       (feature)
  );

  ata_tf_seccount u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cnt_load_ev),
    .load_byte (wr_byte),
    .step      (sector_done),
    .count     (sectors_left)
  );

  always_comb begin
    if (sel.hit_data)     rd_byte = sel.odd_byte ? data_b[LANES-1] : data_b[0];
    else if (sel.hit_ef)  rd_byte = err_bits;
    else if (sel.hit_cnt) rd_byte = sectors_left[BYTE_W-1:0];
    else                  rd_byte = '0;
  end

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      unique case (sel.lane)
        LANE_WORD: host_rdata = data_word;
        LANE_LOW:  host_rdata[BYTE_W-1:0] = rd_byte;
        LANE_HIGH: host_rdata[BUS_W-1 -: BYTE_W] = rd_byte;
        default:   host_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/ata_tf_regfile_chk.sv
module ata_tf_regfile_chk
  import ata_tf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ce_hi_n,
  input logic              ce_lo_n,
  input logic              sector_done,
  input logic              cmd_start,
  input logic              fault_strobe,
  input logic [BUS_W-1:0]  host_rdata,
  input logic [BUS_W-1:0]  data_word,
  input logic [BYTE_W-1:0] feature,
  input logic [CNT_W-1:0]  sectors_left,
  input logic [BYTE_W-1:0] err_bits,
  input logic              cnt_load_ev
);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_hi_n && ce_lo_n) |-> (host_rdata == '0));

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_hi_n && ce_lo_n) |=> ($stable(data_word) && $stable(feature)));

  a_r2_upper_lane_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_hi_n && !ce_lo_n) |-> (host_rdata[BUS_W-1 -: BYTE_W] == '0));

  a_r3_lower_lane_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_hi_n && ce_lo_n) |-> (host_rdata[BYTE_W-1:0] == '0));

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bits & 8'h2A) == '0);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !fault_strobe) |=> (err_bits == '0));

  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sectors_left <= CNT_W'(CNT_MAX));

  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_done && !cnt_load_ev && sectors_left != '0)
      |=> (sectors_left == $past(sectors_left) - CNT_W'(1)));

  a_r8_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_done && !cnt_load_ev && sectors_left == '0) |=> (sectors_left == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sector_done && !cnt_load_ev) |=> $stable(sectors_left));

endmodule

bind ata_tf_regfile ata_tf_regfile_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ce_hi_n      (ce_hi_n),
  .ce_lo_n      (ce_lo_n),
  .sector_done  (sector_done),
  .cmd_start    (cmd_start),
  .fault_strobe (fault_strobe),
  .host_rdata   (host_rdata),
  .data_word    (data_word),
  .feature      (feature),
  .sectors_left (sectors_left),
  .err_bits     (err_bits),
  .cnt_load_ev  (cnt_load_ev)
);

// File: tb/ata_tf_regfile_bench.sv
module ata_tf_regfile_bench;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_hi_n = 1'b1, ce_lo_n = 1'b1, a0 = 1'b0;
  logic [3:0]  reg_ofs = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        cmd_start = 1'b0, sector_done = 1'b0, fault_strobe = 1'b0;
  logic [4:0]  fault_cause = '0;
  logic [15:0] data_word;
  logic [7:0]  feature;
  logic [8:0]  sectors_left;

  int total = 0;
  int bad = 0;

  // bench-side model state
  logic [15:0] m_data = '0;
  logic [7:0]  m_err = '0, m_feat = '0;
  int          m_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  ata_tf_regfile u_ata_tf_regfile (
    .clk(clk), .rst_n(rst_n), .ce_hi_n(ce_hi_n), .ce_lo_n(ce_lo_n), .a0(a0),
    .reg_ofs(reg_ofs), .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cmd_start(cmd_start), .sector_done(sector_done),
    .fault_strobe(fault_strobe), .fault_cause(fault_cause), .data_word(data_word),
    .feature(feature), .sectors_left(sectors_left)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] err_of(input logic [4:0] c);
    logic [7:0] e = '0;
    e[0] = c[0]; e[2] = c[1]; e[4] = c[2]; e[6] = c[3]; e[7] = c[4];
    return e;
  endfunction

  function automatic bit data_ofs(input logic [3:0] o);
    return o == 4'd0 || o == 4'd8 || o == 4'd9;
  endfunction

  function automatic bit ef_ofs(input logic [3:0] o);
    return o == 4'd1 || o == 4'd13;
  endfunction

  function automatic logic [15:0] exp_read(input logic hn, input logic ln, input logic s, input logic [3:0] o);
    logic [7:0] cb = 8'(m_cnt);
    if (!hn && !ln) begin
      if (data_ofs(o)) return m_data;
      if (ef_ofs(o)) return {8'h00, m_err};
      if (o == 4'd2) return {8'h00, cb};
    end else if (hn && !ln) begin
      if (data_ofs(o)) return {8'h00, s ? m_data[15:8] : m_data[7:0]};
      if (ef_ofs(o)) return {8'h00, m_err};
      if (o == 4'd2) return {8'h00, cb};
    end else if (!hn && ln) begin
      if (o == 4'd8 || o == 4'd9) return {m_data[15:8], 8'h00};
      if (ef_ofs(o) || o == 4'd0) return {m_err, 8'h00};
    end
    return 16'h0000;
  endfunction

  function automatic string rd_req(input logic hn, input logic ln, input logic [3:0] o);
    if (hn && ln) return "R9";
    if (ef_ofs(o) || (!hn && ln && o == 4'd0)) return "R4";
    if (o == 4'd2 && !ln) return "R7";
    if (!hn && ln && (o == 4'd8 || o == 4'd9)) return "R3";
    if (data_ofs(o) && !ln) return hn ? "R2" : "R1";
    return "R10";
  endfunction

  task automatic model_edge(input logic hn, input logic ln, input logic s, input logic [3:0] o,
                            input logic wr, input logic [15:0] wd, input logic cs, input logic sd,
                            input logic fs, input logic [4:0] fc);
    bit loaded = 0;
    if (fs) m_err = err_of(fc);
    else if (cs) m_err = '0;
    if (wr) begin
      if (!hn && !ln) begin
        if (data_ofs(o)) m_data = wd;
        else if (ef_ofs(o)) m_feat = wd[7:0];
        else if (o == 4'd2) begin m_cnt = (wd[7:0] == 0) ? 256 : int'(wd[7:0]); loaded = 1; end
      end else if (hn && !ln) begin
        if (data_ofs(o)) begin
          if (s) m_data[15:8] = wd[7:0]; else m_data[7:0] = wd[7:0];
        end else if (ef_ofs(o)) m_feat = wd[7:0];
        else if (o == 4'd2) begin m_cnt = (wd[7:0] == 0) ? 256 : int'(wd[7:0]); loaded = 1; end
      end else if (!hn && ln) begin
        if (o == 4'd8 || o == 4'd9) m_data[15:8] = wd[15:8];
        else if (ef_ofs(o) || o == 4'd0) m_feat = wd[15:8];
      end
    end
    if (!loaded && sd && m_cnt > 0) m_cnt--;
  endtask

  // One bus cycle: compare stored outputs, drive, compare read, clock, advance model.
  task automatic cyc(input logic hn, input logic ln, input logic s, input logic [3:0] o,
                     input logic rd, input logic wr, input logic [15:0] wd,
                     input logic cs = 0, input logic sd = 0, input logic fs = 0,
                     input logic [4:0] fc = '0);
    @(negedge clk);
    check("R1", "data_word", data_word, m_data);
    check("R4", "feature", {8'h00, feature}, {8'h00, m_feat});
    check("R8", "sectors_left", {7'h0, sectors_left}, 16'(m_cnt));
    ce_hi_n = hn; ce_lo_n = ln; a0 = s; reg_ofs = o; host_rd = rd; host_wr = wr;
    host_wdata = wd; cmd_start = cs; sector_done = sd; fault_strobe = fs; fault_cause = fc;
    #1;
    if (rd) check(rd_req(hn, ln, o), "read", host_rdata, exp_read(hn, ln, s, o));
    else    check("R10", "read with rd low", host_rdata, 16'h0000);
    @(posedge clk);
    model_edge(hn, ln, s, o, wr, wd, cs, sd, fs, fc);
  endtask

  task automatic idle_cyc();
    cyc(1, 1, 0, 4'd0, 0, 0, 16'h0);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1c2b3a49;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state
    check("R1", "reset data_word", data_word, 16'h0);
    check("R8", "reset sectors_left", {7'h0, sectors_left}, 16'h0);
    cyc(0, 0, 0, 4'd1, 1, 0, 16'h0);  // R5 error byte reads 0 after reset

    // R1 word write then word read
    cyc(0, 0, 0, 4'd8, 0, 1, 16'hA55A);
    cyc(0, 0, 1, 4'd9, 1, 0, 16'h0);
    check("R1", "word stored", data_word, 16'hA55A);
    // R2 byte reads by a0
    cyc(1, 0, 0, 4'd0, 1, 0, 16'h0);
    cyc(1, 0, 1, 4'd9, 1, 0, 16'h0);
    cyc(1, 0, 1, 4'd8, 0, 1, 16'h00C3);  // odd byte write via lower lane
    idle_cyc();
    check("R2", "odd byte written", data_word, 16'hC35A);
    // R3 odd byte on upper lane
    cyc(0, 1, 0, 4'd8, 1, 0, 16'h0);
    cyc(0, 1, 0, 4'd9, 0, 1, 16'h7E11);
    idle_cyc();
    check("R3", "upper lane write", data_word, 16'h7E5A);

    // R4 feature via upper lane offset 0, and via lower lane offset 13
    cyc(0, 1, 0, 4'd0, 0, 1, 16'h3C00);
    idle_cyc();
    check("R4", "feature upper lane", {8'h0, feature}, 16'h003C);
    cyc(0, 0, 0, 4'd13, 0, 1, 16'h0077);
    idle_cyc();
    check("R4", "feature lower lane", {8'h0, feature}, 16'h0077);

    // R7 zero means 256
    cyc(1, 0, 0, 4'd2, 0, 1, 16'h0000);
    idle_cyc();
    check("R7", "count 0 loads 256", {7'h0, sectors_left}, 16'd256);
    cyc(1, 0, 0, 4'd2, 1, 0, 16'h0);
    repeat (3) cyc(1, 1, 0, 4'd0, 0, 0, 16'h0, 0, 1);
    idle_cyc();
    check("R8", "256 minus 3", {7'h0, sectors_left}, 16'd253);

    // R8 mid-transfer abort keeps remainder; R5 aborted bit
    cyc(0, 0, 0, 4'd2, 0, 1, 16'h0005);
    repeat (2) cyc(1, 1, 0, 4'd0, 0, 0, 16'h0, 0, 1);
    cyc(1, 1, 0, 4'd0, 0, 0, 16'h0, 0, 0, 1, 5'b00010);
    cyc(1, 0, 0, 4'd2, 1, 0, 16'h0);
    check("R8", "remainder after abort", {7'h0, sectors_left}, 16'd3);
    cyc(1, 0, 0, 4'd1, 1, 0, 16'h0);
    // R6 clear, then fault wins over clear
    cyc(1, 1, 0, 4'd0, 0, 0, 16'h0, 1);
    cyc(1, 0, 0, 4'd1, 1, 0, 16'h0);
    cyc(1, 1, 0, 4'd0, 0, 0, 16'h0, 1, 0, 1, 5'b11111);
    cyc(0, 1, 0, 4'd1, 1, 0, 16'h0);  // expects D5 on upper lane
    // R8 count floors at 0
    cyc(1, 0, 0, 4'd2, 0, 1, 16'h0001);
    repeat (3) cyc(1, 1, 0, 4'd0, 0, 0, 16'h0, 0, 1);
    // R9 idle write ignored
    cyc(1, 1, 0, 4'd8, 1, 1, 16'hFFFF);
    // R10 undecoded offsets
    cyc(0, 0, 0, 4'd5, 1, 1, 16'hFFFF);
    cyc(0, 1, 0, 4'd2, 1, 1, 16'hFFFF);
    cyc(1, 0, 0, 4'd9, 0, 0, 16'h0);

    // constrained random
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] o;
      logic [15:0] wd;
      int unsigned pick = $urandom_range(0, 7);
      case (pick)
        0: o = 4'd0; 1: o = 4'd1; 2: o = 4'd2; 3: o = 4'd8;
        4: o = 4'd9; 5: o = 4'd13; default: o = 4'($urandom_range(0, 15));
      endcase
      wd = 16'($urandom());
      if ($urandom_range(0, 9) < 3) wd[7:0] = 8'($urandom_range(0, 3));
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), o,
          1'($urandom_range(0, 1)), $urandom_range(0, 9) < 4, wd,
          $urandom_range(0, 19) == 0, $urandom_range(0, 4) == 0,
          $urandom_range(0, 19) == 0, 5'($urandom()));
    end
    idle_cyc();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule